// File: doc/BRIEF.md
# Coherent Snapshot Reader for a Wide Slow Time Counter

This block lets a fast processor-side read port fetch a very wide time counter that advances in a slow clock domain (for example a 1 Hz tick). The slow side keeps the count in binary and publishes a registered Gray-coded copy. Because the Gray copy moves by one bit per increment, the fast side can sample it at any moment. A sampled value is always either the previous count or the new count.

The fast side brings the Gray word across through a full-width synchronizer. Reading word address 0 captures the whole synchronized value into a snapshot register, in binary. Reads of every other word return slices of that snapshot. A multi-word read that starts at word 0 is therefore coherent: all of its words belong to the same instant, and the value is off by at most one count.

A parameter selects the synchronizer variant. The default uses two ranks of flops. The low-area variant uses one rank: a word-0 read freezes that rank and waits a fixed number of fast clocks, so that metastability can settle, before it takes the snapshot. A small state machine runs the read path. Its states are `ST_IDLE`, where reads are accepted, and `ST_SETTLE`, where the single rank is frozen. Its transitions are:
- `ST_IDLE`→`ST_SETTLE` on a word-0 read in low-area mode.
- `ST_SETTLE`→`ST_SETTLE` while the settle count runs.
- `ST_SETTLE`→`ST_IDLE` when the count expires and the snapshot is taken.
- `ST_IDLE`→`ST_IDLE` in every other case.

Top module: `wide_time_snapshot`

## Requirements
- R1: Reset clears the slow counter, every synchronizer rank, the snapshot, `rd_data` and `rd_valid` to zero, so a word-0 read right after reset returns zero.
- R2: The slow counter increases by exactly one on each `slow_clk` edge with `tick_en` high and holds otherwise. Its published Gray copy is bin ^ (bin >> 1) and changes in at most one bit per slow edge.
- R3: The read port has CNT_W/WORD_W words. Word address w returns bits [w*WORD_W +: WORD_W] of the snapshot, as plain binary.
- R4: A read of word address 0 copies the whole synchronized counter into the snapshot and returns its lowest word. When the slow side has been idle for several fast clocks, the returned value equals the tick count exactly.
- R5: Reads of word addresses other than 0 never update the snapshot. After the counter advances, those reads keep returning the old snapshot until the next word-0 read.
- R6: With LOW_AREA = 0, `rd_valid` and `rd_data` appear on the fast clock edge after the one that samples `rd_en`. `rd_valid` is low in every cycle that follows a cycle without `rd_en`.
- R7: With LOW_AREA = 1, a word-0 read freezes the single synchronizer rank. The snapshot is taken, and `rd_valid` raised, SETTLE_CYC fast clocks after the edge that samples the strobe. Reads of other words keep the one-clock latency of R6.
- R8: In low-area mode, read strobes that arrive while a settle is in progress are ignored. They produce no `rd_valid` pulse and leave the snapshot unchanged.
- R9: REG_G2B selects whether the Gray-to-binary decode is combinational or registered. Both settings return the same binary values at the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| slow_clk | input | 1 | Slow time-base clock |
| slow_rst_n | input | 1 | Active-low reset for the slow domain |
| tick_en | input | 1 | Advance the counter on this slow edge |
| fast_clk | input | 1 | Processor-side clock |
| fast_rst_n | input | 1 | Active-low reset for the fast domain |
| rd_en | input | 1 | One-cycle read strobe |
| rd_addr | input | AW | Word address; 0 takes a new snapshot |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | WORD_W | Word read from the snapshot |

## Verification
The counter is stepped through a table of tick bursts, and after each burst every word is read from two instances. The default instance is 512 bits wide with two ranks and combinational decode. The second is 64 bits wide with one rank and registered decode, so carries cross word boundaries and the two decode styles can be compared on the same counts. A directed sequence reads word 0, advances the counter across a word boundary, and then reads the upper word. This shows whether a slice comes from the frozen snapshot or from the live counter. A second strobe issued during a settle shows whether the state machine ignores it or starts a second capture.

// File: rtl/wts_pkg.sv
package wts_pkg;
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_SETTLE = 1'b1
    } rd_state_e;
endpackage

// File: rtl/wts_slow_counter.sv
module wts_slow_counter #(
    parameter int W = 512
) (
    input  logic         slow_clk,
    input  logic         slow_rst_n,
    input  logic         tick_en,
    output logic [W-1:0] gray_q
);
    logic [W-1:0] bin_q;
    logic [W-1:0] bin_nx;

    assign bin_nx = bin_q + 1'b1;

    always_ff @(posedge slow_clk or negedge slow_rst_n) begin
        if (!slow_rst_n) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else if (tick_en) begin
            bin_q  <= bin_nx;
            gray_q <= bin_nx ^ (bin_nx >> 1);
        end
    end
endmodule

// File: rtl/wts_sync_rank.sv
module wts_sync_rank #(
    parameter int W      = 512,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [W-1:0] q_s;
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     q_s <= '0;
                else if (!hold) q_s <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     q_s <= '0;
                else if (!hold) q_s <= g_stage[s-1].q_s;
            end
        end
    end

    assign q = g_stage[STAGES-1].q_s;
endmodule

// File: rtl/wts_gray2bin.sv
module wts_gray2bin #(
    parameter int W         = 512,
    parameter bit REGISTERED = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray,
    output logic [W-1:0] bin
);
    logic [W-1:0] dec;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dec[i] = ^gray[W-1:i];
    end

    if (REGISTERED) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bin <= '0;
            else        bin <= dec;
        end
    end else begin : g_comb
        assign bin = dec;
    end
endmodule

// File: rtl/wts_read_ctrl.sv
module wts_read_ctrl
    import wts_pkg::*;
#(
    parameter int CNT_W      = 512,
    parameter int WORD_W     = 32,
    parameter bit LOW_AREA   = 1'b0,
    parameter int SETTLE_CYC = 3,
    localparam int NWORDS    = CNT_W / WORD_W,
    localparam int AW        = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    input  logic [CNT_W-1:0]  conv_bin,
    output logic              rank_hold,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);
    localparam int CW = $clog2(SETTLE_CYC) + 1;

    rd_state_e      state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic [CNT_W-1:0] snap_q;
    logic           trigger, word_rd, capture_now;

    assign trigger     = rd_en && (rd_addr == '0) && (state_q == ST_IDLE);
    assign word_rd     = rd_en && (rd_addr != '0) && (state_q == ST_IDLE);
    assign capture_now = LOW_AREA ? ((state_q == ST_SETTLE) && (cnt_q == '0)) : trigger;
    assign rank_hold   = (state_q == ST_SETTLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (LOW_AREA && trigger) begin
                    state_d = ST_SETTLE;
                    cnt_d   = CW'(SETTLE_CYC - 1);
                end
            end
            ST_SETTLE: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs and snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q   <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture_now || word_rd;
            if (capture_now) begin
                snap_q  <= conv_bin;
                rd_data <= conv_bin[WORD_W-1:0];
            end else if (word_rd) begin
                rd_data <= snap_q[int'(rd_addr) * WORD_W +: WORD_W];
            end
        end
    end
endmodule

// File: rtl/wide_time_snapshot.sv
module wide_time_snapshot #(
    parameter int CNT_W      = 512,
    parameter int WORD_W     = 32,
    parameter bit LOW_AREA   = 1'b0,
    parameter int SETTLE_CYC = 3,
    parameter bit REG_G2B    = 1'b0,
    localparam int NWORDS    = CNT_W / WORD_W,
    localparam int AW        = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic              slow_clk,
    input  logic              slow_rst_n,
    input  logic              tick_en,
    input  logic              fast_clk,
    input  logic              fast_rst_n,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);
    localparam int SYNC_STAGES = LOW_AREA ? 1 : 2;

    logic [CNT_W-1:0] slow_gray;
    logic [CNT_W-1:0] sync_gray;
    logic [CNT_W-1:0] conv_bin;
    logic             rank_hold;

    wts_slow_counter #(.W(CNT_W)) u_cnt (
        .slow_clk   (slow_clk),
        .slow_rst_n (slow_rst_n),
        .tick_en    (tick_en),
        .gray_q     (slow_gray)
    );

    wts_sync_rank #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (fast_clk),
        .rst_n (fast_rst_n),
        .hold  (rank_hold),
        .d     (slow_gray),
        .q     (sync_gray)
    );

    wts_gray2bin #(.W(CNT_W), .REGISTERED(REG_G2B)) u_dec (
        .clk   (fast_clk),
        .rst_n (fast_rst_n),
        .gray  (sync_gray),
        .bin   (conv_bin)
    );

    wts_read_ctrl #(
        .CNT_W      (CNT_W),
        .WORD_W     (WORD_W),
        .LOW_AREA   (LOW_AREA),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_ctrl (
        .clk       (fast_clk),
        .rst_n     (fast_rst_n),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .conv_bin  (conv_bin),
        .rank_hold (rank_hold),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/wts_chk.sv
module wts_chk #(
    parameter int CNT_W    = 512,
    parameter int WORD_W   = 32,
    parameter bit LOW_AREA = 1'b0
) (
    input logic              slow_clk,
    input logic              slow_rst_n,
    input logic              tick_en,
    input logic              fast_clk,
    input logic              fast_rst_n,
    input logic              rd_en,
    input logic              rd_valid,
    input logic [WORD_W-1:0] rd_data,
    input logic [CNT_W-1:0]  slow_gray,
    input logic [CNT_W-1:0]  sync_gray,
    input logic              rank_hold
);
    // R2
    gray_step_chk: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        1'b1 |=> ($countones(slow_gray ^ $past(slow_gray)) <= 1));

    // R2
    gray_idle_chk: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        !tick_en |=> $stable(slow_gray));

    // R7
    rank_freeze_chk: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
        rank_hold |=> $stable(sync_gray));

    // R5
    data_hold_chk: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
        !rd_valid |-> $stable(rd_data));

    if (!LOW_AREA) begin : g_two_rank
        // R6
        valid_lat_chk: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
            rd_en |=> rd_valid);

        // R6
        valid_quiet_chk: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
            !rd_en |=> !rd_valid);
    end
endmodule

bind wide_time_snapshot wts_chk #(
    .CNT_W    (CNT_W),
    .WORD_W   (WORD_W),
    .LOW_AREA (LOW_AREA)
) u_wts_chk (
    .slow_clk   (slow_clk),
    .slow_rst_n (slow_rst_n),
    .tick_en    (tick_en),
    .fast_clk   (fast_clk),
    .fast_rst_n (fast_rst_n),
    .rd_en      (rd_en),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .slow_gray  (slow_gray),
    .sync_gray  (sync_gray),
    .rank_hold  (rank_hold)
);

// File: tb/test_wide_time_snapshot.sv
module test_wide_time_snapshot;
    localparam int LA_SETTLE = 3;

    logic fclk = 1'b0;
    logic sclk = 1'b0;
    logic frst_n = 1'b0;
    logic srst_n = 1'b0;
    logic tick = 1'b0;

    logic        m_en = 1'b0;
    logic [3:0]  m_addr = '0;
    logic        m_valid;
    logic [31:0] m_data;

    logic        l_en = 1'b0;
    logic [2:0]  l_addr = '0;
    logic        l_valid;
    logic [7:0]  l_data;

    int checks = 0;
    int errors = 0;
    logic [63:0] total = '0;

    localparam int unsigned TICKS [6] = '{1, 1, 3, 250, 1, 744};

    always #2  fclk = ~fclk;
    always #13 sclk = ~sclk;

    wide_time_snapshot i_wide_time_snapshot (
        .slow_clk (sclk), .slow_rst_n (srst_n), .tick_en (tick),
        .fast_clk (fclk), .fast_rst_n (frst_n),
        .rd_en (m_en), .rd_addr (m_addr), .rd_valid (m_valid), .rd_data (m_data)
    );

    wide_time_snapshot #(
        .CNT_W (64), .WORD_W (8), .LOW_AREA (1'b1), .SETTLE_CYC (LA_SETTLE), .REG_G2B (1'b1)
    ) i_wide_time_snapshot_la (
        .slow_clk (sclk), .slow_rst_n (srst_n), .tick_en (tick),
        .fast_clk (fclk), .fast_rst_n (frst_n),
        .rd_en (l_en), .rd_addr (l_addr), .rd_valid (l_valid), .rd_data (l_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd_main(input int addr, output logic [31:0] d, output logic v);
        @(negedge fclk); m_en = 1'b1; m_addr = 4'(addr);
        @(negedge fclk); m_en = 1'b0;
        v = m_valid; d = m_data;
    endtask

    task automatic rd_la(input int addr, output logic [7:0] d, output int lat);
        @(negedge fclk); l_en = 1'b1; l_addr = 3'(addr);
        @(negedge fclk); l_en = 1'b0;
        lat = 0;
        while (!l_valid && lat < 20) begin
            @(negedge fclk); lat++;
        end
        d = l_data;
    endtask

    task automatic do_ticks(input int n);
        @(negedge sclk); tick = 1'b1;
        repeat (n) @(negedge sclk);
        tick = 1'b0;
        total += 64'(n);
        repeat (12) @(negedge fclk);
    endtask

    initial begin
        repeat (200000) @(posedge fclk);
        checks++; errors++;
        $display("FAIL watchdog expired (all requirements)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] md;
        logic        mv;
        logic [7:0]  ld;
        int          lat;
        int          vcount;

        repeat (5) @(negedge fclk);
        frst_n = 1'b1; srst_n = 1'b1;
        @(negedge fclk);

        // R1 reset state
        chk(m_valid == 1'b0, "R1 valid after reset", 64'(m_valid), 0);
        chk(m_data == '0, "R1 data after reset", 64'(m_data), 0);
        chk(l_valid == 1'b0, "R1 la valid after reset", 64'(l_valid), 0);
        rd_main(0, md, mv);
        chk(mv && md == '0, "R1 word0 read after reset", 64'(md), 0);
        rd_la(0, ld, lat);
        chk(ld == '0, "R1 la word0 read after reset", 64'(ld), 0);

        // table walk: R2 R3 R4 R6 R7 R9
        foreach (TICKS[k]) begin
            do_ticks(int'(TICKS[k]));
            for (int w = 0; w < 16; w++) begin
                rd_main(w, md, mv);
                chk(mv, "R6 valid one clock after strobe", 64'(mv), 1);
                chk(md == 32'(total >> (32 * w)), "R3/R4 main word value", 64'(md), 64'(32'(total >> (32 * w))));
            end
            for (int w = 0; w < 8; w++) begin
                rd_la(w, ld, lat);
                chk(lat == ((w == 0) ? LA_SETTLE : 0), "R7 la latency", 64'(lat), 64'((w == 0) ? LA_SETTLE : 0));
                chk(ld == 8'(total >> (8 * w)), "R9 la word value", 64'(ld), 64'(8'(total >> (8 * w))));
            end
        end

        // R2 counter holds without ticks
        repeat (200) @(negedge fclk);
        rd_main(0, md, mv);
        chk(md == 32'(total), "R2 hold without tick", 64'(md), 64'(32'(total)));

        // R5 snapshot coherence across a word boundary (total 1000 -> 1031)
        rd_la(0, ld, lat);
        chk(ld == 8'(total), "R4 la capture", 64'(ld), 64'(8'(total)));
        begin
            logic [7:0] old_hi;
            old_hi = 8'(total >> 8);
            do_ticks(31);
            rd_la(1, ld, lat);
            chk(ld == old_hi, "R5 upper word from old snapshot", 64'(ld), 64'(old_hi));
        end
        rd_la(0, ld, lat);
        chk(ld == 8'(total), "R4 new capture low", 64'(ld), 64'(8'(total)));
        rd_la(1, ld, lat);
        chk(ld == 8'(total >> 8), "R5 upper word after new capture", 64'(ld), 64'(8'(total >> 8)));
        rd_main(0, md, mv);
        chk(md == 32'(total), "R4 main recapture", 64'(md), 64'(32'(total)));

        // R6 no valid without strobe
        @(negedge fclk);
        chk(m_valid == 1'b0, "R6 valid low without strobe", 64'(m_valid), 0);

        // R8 strobe during settle ignored
        vcount = 0;
        @(negedge fclk); l_en = 1'b1; l_addr = 3'd0;
        @(negedge fclk); l_en = 1'b1; l_addr = 3'd1;
        if (l_valid) vcount++;
        @(negedge fclk); l_en = 1'b0;
        if (l_valid) vcount++;
        for (int i = 0; i < 10; i++) begin
            @(negedge fclk);
            if (l_valid) vcount++;
        end
        chk(vcount == 1, "R8 one valid for strobes during settle", 64'(vcount), 1);
        chk(l_data == 8'(total), "R8 captured low word", 64'(l_data), 64'(8'(total)));
        rd_la(1, ld, lat);
        chk(ld == 8'(total >> 8), "R8 snapshot unchanged by ignored strobe", 64'(ld), 64'(8'(total >> 8)));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule